// File: doc/BRIEF.md
# DRAM Power-Up Initialisation and CAS-before-RAS Refresh Sequencer

This block keeps an asynchronous 512-row DRAM alive. After reset it holds both strobes high and stays silent for a fixed start-up delay. It then runs a counted burst of CAS-before-RAS refresh cycles and raises `ready_o`. From then on it schedules one refresh per row interval, which is the 8 ms retention window divided by 512 rows. The device supplies the row address itself, so the block has no address or write-enable outputs.

The block shares the DRAM strobes with the access controller. It asks for them on `ref_req_o` and uses them only after `ref_gnt_i` is high. Refreshes that fall due while the grant is withheld are counted up to a small limit. When the grant returns, they are issued back to back. The clock period and every timing value are parameters given in nanoseconds. Each timing value becomes a whole number of clock cycles, rounded up, with a minimum of one cycle. In the requirements below this conversion is written ceil(x / clock).

Top module: `dram_cbr_refresh`

## Requirements
- R1: During reset, and for STARTUP_C = ceil(T_STARTUP_NS / T_CLK_NS) rising edges after reset is released, `ras_n_o` and `cas_n_o` are high and `ref_req_o` and `ready_o` are low. `ref_req_o` first goes high right after edge STARTUP_C, which is 10000 with the defaults.
- R2: Exactly INIT_REFRESHES refresh cycles (default 8) are run before `ready_o` rises. `ready_o` rises in the cycle in which the last of them completes.
- R3: In every refresh cycle, CAS goes low and stays low for CSR_C = ceil(T_CSR_NS / clock) cycles while RAS is still high, and only then does RAS go low. CAS then stays low for CHR_C = ceil(T_CHR_NS / clock) cycles and rises while RAS is still low.
- R4: RAS stays low for RAS_C = ceil(T_RAS_NS / clock) cycles in each refresh cycle.
- R5: Before each CAS fall, both strobes have been high for at least RP_C = ceil(T_RP_NS / clock) cycles, plus at least RPC_C = ceil(T_RPC_NS / clock) cycles before CAS falls.
- R6: While `ref_req_o` is low, both strobes are high. CAS falls only after `ref_gnt_i` was high in the previous cycle. While the grant is withheld, the strobes stay high.
- R7: `ref_req_o` stays high until the last refresh cycle's RP_C precharge cycles have passed with both strobes high.
- R8: Once ready, with the grant given at once, RAS falls exactly every REFI_C = ceil(T_REFI_NS / clock) cycles, which is 1563 with the defaults.
- R9: While the grant is withheld, the number of due refreshes is held at no more than BACKLOG_MAX (default 4). When the grant returns, exactly that many refresh cycles run back to back, and `ref_req_o` stays high throughout.
- R10: Once `ready_o` is high, it stays high until the next reset.
- R11: Once ready, `ref_req_o` is low whenever no refresh is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_gnt_i | input | 1 | Strobe ownership granted by the access controller |
| ref_req_o | output | 1 | Request for strobe ownership |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| ready_o | output | 1 | High once the initialisation burst has finished; data accesses are withheld until then |

## Verification
The assertions assume the access controller raises `ref_gnt_i` only while `ref_req_o` is high. They also assume that, once the grant is given, it is held until the request drops. Cutting a grant short partway through a refresh cycle is outside the contract. The bench keeps within this rule in two ways. It either ties the grant to the request, or it holds the grant low and restores it only while a request is pending.

// File: rtl/dram_rfs_pkg.sv
package dram_rfs_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_SETUP,
      SQ_CASLEAD,
      SQ_STROBE,
      SQ_PRECH
   } seq_state_e;

   typedef enum logic [1:0] {
      PH_POWERUP,
      PH_INIT,
      PH_RUN
   } phase_e;

   // Whole cycles covering a time in ns, never less than one.
   function automatic int unsigned ns2cyc(input int unsigned t_ns, input int unsigned clk_ns);
      int unsigned c;
      c = (t_ns + clk_ns - 1) / clk_ns;
      if (c == 0) c = 1;
      return c;
   endfunction

endpackage

// File: rtl/dram_rfs_tick.sv
module dram_rfs_tick #(
   parameter int unsigned LIMIT   = 16,
   parameter bit          ONESHOT = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic fire_o
);
   localparam int unsigned W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   logic [W-1:0] cnt_q;
   logic         at_last;

   assign at_last = (cnt_q == LAST);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("dram_rfs_tick: LIMIT must be at least 2");
      end
      if (ONESHOT) begin : g_once
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                cnt_q <= '0;
            else if (en_i && !at_last)  cnt_q <= cnt_q + W'(1);
         end
         assign fire_o = at_last;
      end else begin : g_wrap
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     cnt_q <= '0;
            else if (en_i)   cnt_q <= at_last ? '0 : cnt_q + W'(1);
         end
         assign fire_o = en_i && at_last;
      end
   endgenerate
endmodule

// File: rtl/dram_rfs_backlog.sv
module dram_rfs_backlog #(
   parameter int unsigned MAX = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic inc_i,
   input  logic dec_i,
   output logic nz_o
);
   localparam int unsigned W = $clog2(MAX + 1);
   localparam logic [W-1:0] TOP = W'(MAX);

   logic [W-1:0] cnt_q;

   generate
      if (MAX < 1) begin : g_bad_max
         $error("dram_rfs_backlog: MAX must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else begin
         case ({inc_i, dec_i})
            2'b10:   if (cnt_q != TOP) cnt_q <= cnt_q + W'(1);
            2'b01:   if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign nz_o = (cnt_q != '0);
endmodule

// File: rtl/dram_rfs_cbr.sv
module dram_rfs_cbr
   import dram_rfs_pkg::*;
#(
   parameter int unsigned RPC_C = 1,
   parameter int unsigned CSR_C = 1,
   parameter int unsigned CHR_C = 1,
   parameter int unsigned RAS_C = 7,
   parameter int unsigned RP_C  = 6
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic go_i,
   input  logic gnt_i,
   output logic req_o,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic done_o
);
   localparam int unsigned M1   = (RPC_C > CSR_C) ? RPC_C : CSR_C;
   localparam int unsigned M2   = (RAS_C > RP_C)  ? RAS_C : RP_C;
   localparam int unsigned MAXC = (M1 > M2) ? M1 : M2;
   localparam int unsigned W    = $clog2(MAXC + 1);
   localparam logic [W-1:0] L_SETUP = W'(RPC_C - 1);
   localparam logic [W-1:0] L_LEAD  = W'(CSR_C - 1);
   localparam logic [W-1:0] L_STRB  = W'(RAS_C - 1);
   localparam logic [W-1:0] L_PRE   = W'(RP_C - 1);
   localparam logic [W-1:0] HOLD    = W'(CHR_C);

   generate
      if (RAS_C <= CHR_C) begin : g_bad_hold
         $error("dram_rfs_cbr: RAS low time must exceed CAS hold time");
      end
   endgenerate

   seq_state_e   state_q, state_d;
   logic [W-1:0] cnt_q, cnt_d;
   logic         ras_d, cas_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q + W'(1);
      case (state_q)
         SQ_IDLE: begin
            cnt_d = '0;
            if (go_i && gnt_i) state_d = SQ_SETUP;
         end
         SQ_SETUP:   if (cnt_q == L_SETUP) begin state_d = SQ_CASLEAD; cnt_d = '0; end
         SQ_CASLEAD: if (cnt_q == L_LEAD)  begin state_d = SQ_STROBE;  cnt_d = '0; end
         SQ_STROBE:  if (cnt_q == L_STRB)  begin state_d = SQ_PRECH;   cnt_d = '0; end
         SQ_PRECH:   if (cnt_q == L_PRE)   begin state_d = SQ_IDLE;    cnt_d = '0; end
         default: begin
            state_d = SQ_IDLE;
            cnt_d   = '0;
         end
      endcase
      ras_d = (state_d != SQ_STROBE);
      cas_d = !((state_d == SQ_CASLEAD) || ((state_d == SQ_STROBE) && (cnt_d < HOLD)));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
         ras_n_o <= 1'b1;
         cas_n_o <= 1'b1;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         ras_n_o <= ras_d;
         cas_n_o <= cas_d;
      end
   end

   assign done_o = (state_q == SQ_PRECH) && (cnt_q == L_PRE);
   assign req_o  = go_i || (state_q != SQ_IDLE);
endmodule

// File: rtl/dram_cbr_refresh.sv
module dram_cbr_refresh
   import dram_rfs_pkg::*;
#(
   parameter int unsigned T_CLK_NS       = 10,
   parameter int unsigned T_STARTUP_NS   = 100_000,
   parameter int unsigned T_REFI_NS      = 15_625,
   parameter int unsigned T_RPC_NS       = 10,
   parameter int unsigned T_CSR_NS       = 10,
   parameter int unsigned T_CHR_NS       = 10,
   parameter int unsigned T_RAS_NS       = 70,
   parameter int unsigned T_RP_NS        = 60,
   parameter int unsigned T_RC_NS        = 130,
   parameter int unsigned INIT_REFRESHES = 8,
   parameter int unsigned BACKLOG_MAX    = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ref_gnt_i,
   output logic ref_req_o,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic ready_o
);
   localparam int unsigned STARTUP_C = ns2cyc(T_STARTUP_NS, T_CLK_NS);
   localparam int unsigned REFI_C    = ns2cyc(T_REFI_NS, T_CLK_NS);
   localparam int unsigned RPC_C     = ns2cyc(T_RPC_NS, T_CLK_NS);
   localparam int unsigned CSR_C     = ns2cyc(T_CSR_NS, T_CLK_NS);
   localparam int unsigned CHR_C     = ns2cyc(T_CHR_NS, T_CLK_NS);
   localparam int unsigned RAS_C     = ns2cyc(T_RAS_NS, T_CLK_NS);
   localparam int unsigned RP_C      = ns2cyc(T_RP_NS, T_CLK_NS);
   localparam int unsigned IW        = $clog2(INIT_REFRESHES + 1);
   localparam logic [IW-1:0] INIT_N  = IW'(INIT_REFRESHES);

   generate
      if (T_RAS_NS + T_RP_NS < T_RC_NS) begin : g_bad_rc
         $error("dram_cbr_refresh: RAS low plus precharge shorter than cycle time");
      end
      if (INIT_REFRESHES < 1) begin : g_bad_init
         $error("dram_cbr_refresh: at least one initialisation refresh needed");
      end
      if (REFI_C <= RPC_C + CSR_C + RAS_C + RP_C + 1) begin : g_bad_refi
         $error("dram_cbr_refresh: refresh interval shorter than one refresh cycle");
      end
   endgenerate

   phase_e       phase_q;
   logic [IW-1:0] init_left_q;
   logic         boot_done, refi_tick, backlog_nz, seq_done, go;

   dram_rfs_tick #(.LIMIT(STARTUP_C), .ONESHOT(1'b1)) u_boot (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (1'b1),
      .fire_o(boot_done)
   );

   dram_rfs_tick #(.LIMIT(REFI_C), .ONESHOT(1'b0)) u_refi (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (phase_q == PH_RUN),
      .fire_o(refi_tick)
   );

   dram_rfs_backlog #(.MAX(BACKLOG_MAX)) u_backlog (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (refi_tick),
      .dec_i (seq_done && (phase_q == PH_RUN)),
      .nz_o  (backlog_nz)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q     <= PH_POWERUP;
         init_left_q <= INIT_N;
      end else begin
         case (phase_q)
            PH_POWERUP: if (boot_done) phase_q <= PH_INIT;
            PH_INIT: if (seq_done) begin
               init_left_q <= init_left_q - IW'(1);
               if (init_left_q == IW'(1)) phase_q <= PH_RUN;
            end
            default: phase_q <= PH_RUN;
         endcase
      end
   end

   assign go = ((phase_q == PH_INIT) && (init_left_q != '0)) ||
               ((phase_q == PH_RUN) && backlog_nz);

   dram_rfs_cbr #(
      .RPC_C(RPC_C), .CSR_C(CSR_C), .CHR_C(CHR_C), .RAS_C(RAS_C), .RP_C(RP_C)
   ) u_cbr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .go_i   (go),
      .gnt_i  (ref_gnt_i),
      .req_o  (ref_req_o),
      .ras_n_o(ras_n_o),
      .cas_n_o(cas_n_o),
      .done_o (seq_done)
   );

   assign ready_o = (phase_q == PH_RUN);
endmodule

// File: rtl/dram_cbr_refresh_chk.sv
module dram_cbr_refresh_chk
   import dram_rfs_pkg::*;
#(
   parameter int unsigned T_CLK_NS       = 10,
   parameter int unsigned T_CSR_NS       = 10,
   parameter int unsigned T_CHR_NS       = 10,
   parameter int unsigned T_RAS_NS       = 70,
   parameter int unsigned T_RP_NS        = 60,
   parameter int unsigned INIT_REFRESHES = 8
) (
   input logic clk_i,
   input logic rst_ni,
   input logic ref_gnt_i,
   input logic ref_req_o,
   input logic ras_n_o,
   input logic cas_n_o,
   input logic ready_o
);
   localparam int unsigned CSR_C = ns2cyc(T_CSR_NS, T_CLK_NS);
   localparam int unsigned CHR_C = ns2cyc(T_CHR_NS, T_CLK_NS);
   localparam int unsigned RAS_C = ns2cyc(T_RAS_NS, T_CLK_NS);
   localparam int unsigned RP_C  = ns2cyc(T_RP_NS, T_CLK_NS);

   logic [15:0] cas_lo, ras_lo, both_hi, rises;
   logic        ras_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cas_lo  <= '0;
         ras_lo  <= '0;
         both_hi <= '0;
         rises   <= '0;
         ras_q   <= 1'b1;
      end else begin
         ras_q <= ras_n_o;
         if (cas_n_o)             cas_lo <= '0;
         else if (cas_lo != '1)   cas_lo <= cas_lo + 16'd1;
         if (ras_n_o)             ras_lo <= '0;
         else if (ras_lo != '1)   ras_lo <= ras_lo + 16'd1;
         if (!(ras_n_o && cas_n_o)) both_hi <= '0;
         else if (both_hi != '1)    both_hi <= both_hi + 16'd1;
         if (ras_n_o && !ras_q && rises != '1) rises <= rises + 16'd1;
      end
   end

   // R3
   csr_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ras_n_o) |-> (!cas_n_o && cas_lo >= 16'(CSR_C)));
   // R3
   chr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cas_n_o) |-> (!ras_n_o && ras_lo >= 16'(CHR_C)));
   // R4
   ras_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ras_n_o) |-> (ras_lo >= 16'(RAS_C)));
   // R5
   precharge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cas_n_o) |-> (both_hi >= 16'(RP_C)));
   // R6
   idle_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ref_req_o |-> (ras_n_o && cas_n_o));
   // R6
   grant_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cas_n_o) |-> $past(ref_gnt_i));
   // R7
   release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ref_req_o) |-> (both_hi >= 16'(RP_C)));
   // R2
   init_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ready_o) |-> (rises == 16'(INIT_REFRESHES)));
   // R10
   ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |=> ready_o);
endmodule

bind dram_cbr_refresh dram_cbr_refresh_chk #(
   .T_CLK_NS      (T_CLK_NS),
   .T_CSR_NS      (T_CSR_NS),
   .T_CHR_NS      (T_CHR_NS),
   .T_RAS_NS      (T_RAS_NS),
   .T_RP_NS       (T_RP_NS),
   .INIT_REFRESHES(INIT_REFRESHES)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .ref_gnt_i(ref_gnt_i),
   .ref_req_o(ref_req_o),
   .ras_n_o  (ras_n_o),
   .cas_n_o  (cas_n_o),
   .ready_o  (ready_o)
);

// File: tb/tb_dram_cbr_refresh.sv
module tb_dram_cbr_refresh;
   localparam int CLK_NS    = 10;
   localparam int STARTUP_C = (100_000 + CLK_NS - 1) / CLK_NS;
   localparam int REFI_C    = (15_625 + CLK_NS - 1) / CLK_NS;
   localparam int CSR_C     = 1;
   localparam int CHR_C     = 1;
   localparam int RAS_C     = 7;
   localparam int RP_C      = 6;
   localparam int INIT_N    = 8;
   localparam int BACKLOG   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gnt_auto = 1'b0;
   logic ref_gnt, ref_req, ras_n, cas_n, ready;

   int vectors = 0;
   int miscompares = 0;

   always #(CLK_NS / 2) clk = ~clk;

   assign ref_gnt = gnt_auto & ref_req;

   dram_cbr_refresh #(.T_CLK_NS(CLK_NS)) dut (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .ref_gnt_i(ref_gnt),
      .ref_req_o(ref_req),
      .ras_n_o  (ras_n),
      .cas_n_o  (cas_n),
      .ready_o  (ready)
   );

   // Strobe monitor, sampled at the falling edge.
   int cyc, ras_falls, last_fall, spacing;
   int cas_low_run, ras_low_run, high_run;
   int lead_bad, hold_bad, low_bad, gap_bad, idle_bad;
   logic pr_ras, pr_cas, pr_gnt;

   always @(negedge clk) begin
      if (!rst_n) begin
         cyc = 0; ras_falls = 0; last_fall = 0; spacing = 0;
         cas_low_run = 0; ras_low_run = 0; high_run = 0;
         lead_bad = 0; hold_bad = 0; low_bad = 0; gap_bad = 0; idle_bad = 0;
         pr_ras = 1'b1; pr_cas = 1'b1; pr_gnt = 1'b0;
      end else begin
         cyc++;
         if (pr_ras && !ras_n) begin
            ras_falls++;
            spacing = cyc - last_fall;
            last_fall = cyc;
            if (cas_n || cas_low_run != CSR_C) lead_bad++;
         end
         if (!pr_ras && ras_n && ras_low_run != RAS_C) low_bad++;
         if (!pr_cas && cas_n && (ras_n || ras_low_run != CHR_C)) hold_bad++;
         if (pr_cas && !cas_n) begin
            if (high_run < RP_C) gap_bad++;
            if (!pr_gnt) idle_bad++;
         end
         if (!ref_req && !(ras_n && cas_n)) idle_bad++;
         cas_low_run = cas_n ? 0 : cas_low_run + 1;
         ras_low_run = ras_n ? 0 : ras_low_run + 1;
         high_run    = (ras_n && cas_n) ? high_run + 1 : 0;
         pr_ras = ras_n; pr_cas = cas_n; pr_gnt = ref_gnt;
      end
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic t_reset();
      repeat (4) step();
      check(ras_n == 1'b1, "R1 ras_n in reset", ras_n, 1);
      check(cas_n == 1'b1, "R1 cas_n in reset", cas_n, 1);
      check(ref_req == 1'b0, "R1 req in reset", ref_req, 0);
      check(ready == 1'b0, "R1 ready in reset", ready, 0);
   endtask

   task automatic t_startup();
      int n = 0;
      int bad = 0;
      rst_n = 1'b1;
      while (!ref_req && n < STARTUP_C + 20) begin
         step();
         n++;
         if (!ref_req && (!ras_n || !cas_n || ready)) bad++;
      end
      check(n == STARTUP_C, "R1 first request edge", n, STARTUP_C);
      check(bad == 0, "R1 quiet during start-up", bad, 0);
   endtask

   task automatic t_init();
      int f0 = ras_falls;
      int n = 0;
      while (!ready && n < 2000) begin
         step();
         n++;
      end
      check(ras_falls - f0 == INIT_N, "R2 init refresh count", ras_falls - f0, INIT_N);
      check(ref_req == 1'b0, "R7 request dropped at ready", ref_req, 0);
      check(lead_bad == 0, "R3 CAS lead before RAS", lead_bad, 0);
      check(hold_bad == 0, "R3 CAS hold after RAS", hold_bad, 0);
      check(low_bad == 0, "R4 RAS low width", low_bad, 0);
      check(gap_bad == 0, "R5 precharge before CAS", gap_bad, 0);
      check(idle_bad == 0, "R6 strobes only under grant", idle_bad, 0);
   endtask

   task automatic t_quiet();
      int req_seen = 0;
      int rdy_lost = 0;
      repeat (1000) begin
         step();
         if (ref_req) req_seen++;
         if (!ready) rdy_lost++;
      end
      check(req_seen == 0, "R11 no request without due refresh", req_seen, 0);
      check(rdy_lost == 0, "R10 ready held", rdy_lost, 0);
   endtask

   task automatic wait_fall();
      int f0 = ras_falls;
      int n = 0;
      while (ras_falls == f0 && n < 2 * REFI_C) begin
         step();
         n++;
      end
   endtask

   task automatic t_interval();
      wait_fall();
      wait_fall();
      check(spacing == REFI_C, "R8 refresh spacing a", spacing, REFI_C);
      wait_fall();
      check(spacing == REFI_C, "R8 refresh spacing b", spacing, REFI_C);
   endtask

   task automatic t_backlog();
      int moved = 0;
      int f0;
      int n = 0;
      int hr = 0;
      while (ref_req) step();
      gnt_auto = 1'b0;
      repeat (6 * REFI_C) begin
         step();
         if (!ras_n || !cas_n) moved++;
      end
      check(moved == 0, "R6 strobes idle while grant withheld", moved, 0);
      check(ref_req == 1'b1, "R9 request pending while withheld", ref_req, 1);
      f0 = ras_falls;
      gnt_auto = 1'b1;
      while (ref_req && n < 1000) begin
         step();
         n++;
      end
      hr = high_run;
      check(ras_falls - f0 == BACKLOG, "R9 back-to-back burst length", ras_falls - f0, BACKLOG);
      check(hr > RP_C, "R7 precharge before release", hr, RP_C + 1);
      check(gap_bad == 0 && lead_bad == 0, "R5 burst spacing and order", gap_bad + lead_bad, 0);
      repeat (200) step();
      check(ref_req == 1'b0 && ready == 1'b1, "R11 idle after burst", ref_req, 0);
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      gnt_auto = 1'b1;
      t_reset();
      t_startup();
      t_init();
      t_quiet();
      t_interval();
      t_backlog();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule